// File: doc/BRIEF.md
# Bank-Paged Control Register File

This block is the host-facing register file of a multi-channel line-interface controller. The address space is five bits wide. The top address, 1Fh, is a bank pointer. The value held in the pointer decides which of four register banks the other 31 addresses (00h–1Eh) reach. The pointer can be read and written whatever bank is selected. It resets to the primary bank, so host software written for a layout that knows only that bank and treats 1Fh as reserved keeps working with no change.

The host port is a plain synchronous strobe interface with no handshake. A write takes effect at the clock edge where `wr_en` is high. A read samples `addr` at the edge where `rd_en` is high. The result is registered onto `rd_data` and holds there until the next read. Each channel has an event input that sets one bit of a latched interrupt-status register. That register clears either on read (the default) or on a write of ones, as a control bit selects. The interrupt output is high while any enabled status bit is set.

Top module: `bank_regfile`

## Requirements
- R1: Address 1Fh reads back the last value written to it, from any bank and for any value, including codes that select no bank.
- R2: After reset the pointer is 00h (primary bank), every storage register reads 00h, the status register is 00h, the clear policy is clear-on-read and `irq` is low.
- R3: Pointer code 00h selects the primary bank, AAh the secondary bank, 01h the per-channel bank and 02h the test-pattern bank. Writes through one bank never change registers of another.
- R4: In the primary bank, addresses 00h–14h are read/write storage (14h is the interrupt enable mask, bit i for channel i) and 15h is the interrupt status. Addresses 16h–1Eh read 00h and ignore writes.
- R5: In the secondary bank, addresses 00h, 01h and 03h–06h are read/write storage. Addresses 02h and 07h–1Eh read 00h and ignore writes.
- R6: In the per-channel bank, 00h–07h and 1Eh are read/write storage, and bit 0 of 1Eh selects the clear policy (0 clear-on-read, 1 clear-on-write). In the test-pattern bank, 00h–08h are storage. All other addresses of both banks read 00h and ignore writes.
- R7: With a pointer value other than the four codes, every address 00h–1Eh reads 00h and writes to them change no register.
- R8: A one-cycle pulse on `chan_evt[i]` sets status bit i, and the bit stays set until it is cleared.
- R9: In clear-on-read mode, a read of status returns its value and clears every bit at the same edge. Writes to status are ignored.
- R10: In clear-on-write mode, a write to status clears exactly the bits written as 1. Reads leave status unchanged.
- R11: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R12: `irq` equals the OR of (status AND enable mask). It falls in the cycle after the clear that empties the enabled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read result, held until the next read |
| chan_evt | input | 8 | Per-channel event pulses that set status bits |
| irq | output | 1 | Interrupt output, OR of enabled status bits |

## Verification
The paging is tested by writing distinct patterns at the same offset in each bank and at unmapped offsets. Each read shows whether the data came from the selected bank, leaked from another bank or came from a hole, and a pointer value outside the defined codes shows whether unknown codes fall into the reserved space. The status path is tested with single events, multi-bit events, partial write masks and events that collide with a clear. These tell the two clear policies apart and show that an event survives a clear in the same cycle. The interrupt is sampled with enabled and masked bits to separate the OR of all status bits from the OR of the enabled bits only.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int NBANK  = 4;

  // bank indices inside the generated bank array
  localparam int IDX_PRI = 0;
  localparam int IDX_SEC = 1;
  localparam int IDX_CHN = 2;
  localparam int IDX_PAT = 3;

  // pointer code that selects each bank, indexed as above
  localparam logic [DATA_W-1:0] BANK_CODE [NBANK] = '{8'h00, 8'hAA, 8'h01, 8'h02};

  // bit a set: offset a is plain storage in that bank
  localparam logic [31:0] BANK_MASK [NBANK] = '{
    32'h001F_FFFF,   // primary: 00-14
    32'h0000_007B,   // secondary: 00,01,03-06
    32'h4000_00FF,   // per-channel: 00-07, 1E
    32'h0000_01FF    // test-pattern: 00-08
  };

  localparam logic [ADDR_W-1:0] EN_OFS   = 5'h14;
  localparam logic [ADDR_W-1:0] STAT_OFS = 5'h15;
  localparam logic [ADDR_W-1:0] POL_OFS  = 5'h1E;
endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import bank_regfile_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    ptr_o,
  output logic [NBANK-1:0] sel_o
);
  logic [DW-1:0] ptr_q;
  logic          ptr_we;

  assign ptr_we = wr_en && (addr == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= wr_data;
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_sel
    assign sel_o[k] = (ptr_q == BANK_CODE[k]);
  end

  assign ptr_o = ptr_q;

  // R1: pointer takes the written value on the next edge
  a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_o == $past(wr_data)));
  // R3: at most one bank is reached at a time
  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int             AW   = 5,
  parameter int             DW   = 8,
  parameter logic [2**AW-1:0] MASK = '1,
  parameter int             TAP  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] tap_o
);
  localparam int NREG = 2**AW - 1;

  logic [NREG-1:0][DW-1:0] mem;
  logic                    hit;

  assign hit = sel && (addr != '1) && MASK[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mem <= '0;
    else if (hit && wr_en)   mem[addr] <= wr_data;
  end

  assign rd_data = hit ? mem[addr] : '0;
  assign tap_o   = mem[TAP];
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           rd_clr,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wr_mask,
  input  logic [NCH-1:0] en,
  input  logic           cow,
  output logic [NCH-1:0] status_o,
  output logic           irq_o
);
  logic [NCH-1:0] status_q;
  logic [NCH-1:0] clr;

  always_comb begin
    clr = '0;
    if (cow) begin
      if (wr_clr) clr = wr_mask;
    end else begin
      if (rd_clr) clr = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | evt;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en);

  // R11: a bit hit by an event is set on the next edge regardless of clears
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status_o & $past(evt)) == $past(evt)));
  // R9: clear-on-read leaves only the events of the read cycle
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !cow) |=> (status_o == $past(evt)));
  // R10: clear-on-write removes exactly the written ones
  a_r10_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && cow) |=> (status_o == (($past(status_o) & ~$past(wr_mask)) | $past(evt))));
  // R8: with no clear, set bits are held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_clr || wr_clr) |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R12: no interrupt while status is empty
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> !irq_o);
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] chan_evt,
  output logic          irq
);
  logic [DW-1:0]              ptr;
  logic [NBANK-1:0]           sel;
  logic [NBANK-1:0][DW-1:0]   bank_rd;
  logic [NBANK-1:0][DW-1:0]   tap;
  logic [DW-1:0]              status;
  logic [DW-1:0]              rd_mux;
  logic [DW-1:0]              rd_q;
  logic                       stat_hit;
  logic                       unused_taps;

  bank_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .ptr_o(ptr), .sel_o(sel)
  );

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    localparam int TAP_K = (k == IDX_PRI) ? int'(EN_OFS) :
                           (k == IDX_CHN) ? int'(POL_OFS) : 0;
    rf_bank #(.AW(AW), .DW(DW), .MASK(BANK_MASK[k][2**AW-1:0]), .TAP(TAP_K)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(sel[k]), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(bank_rd[k]), .tap_o(tap[k])
    );
  end

  assign stat_hit = sel[IDX_PRI] && (addr == STAT_OFS);

  irq_status #(.NCH(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(chan_evt),
    .rd_clr(rd_en && stat_hit), .wr_clr(wr_en && stat_hit),
    .wr_mask(wr_data), .en(tap[IDX_PRI]), .cow(tap[IDX_CHN][0]),
    .status_o(status), .irq_o(irq)
  );

  assign unused_taps = ^{tap[IDX_SEC], tap[IDX_PAT], tap[IDX_CHN][DW-1:1]};

  always_comb begin
    rd_mux = '0;
    if (addr == '1) begin
      rd_mux = ptr;
    end else if (stat_hit) begin
      rd_mux = status;
    end else begin
      for (int k = 0; k < NBANK; k++) rd_mux = rd_mux | bank_rd[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  // R7: an undefined pointer code exposes only the pointer itself
  a_r7_bad_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr != '1) && (sel == '0)) |=> (rd_data == '0));
  // R1: a read of the top address returns the pointer from any bank
  a_r1_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == '1)) |=> (rd_data == $past(ptr)));
endmodule

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NV = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] chan_evt = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bank_regfile #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .chan_evt(chan_evt), .irq(irq)
  );

  // {write, requirement, address, data, expected read}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 4'd1, 5'h1F, 8'h00, 8'h00},  // R1
    {1'b0, 4'd1, 5'h1F, 8'h00, 8'h00},  // R1
    {1'b1, 4'd4, 5'h00, 8'h11, 8'h00},  // R4
    {1'b1, 4'd4, 5'h14, 8'h05, 8'h00},  // R4 enable mask
    {1'b1, 4'd4, 5'h16, 8'h33, 8'h00},  // R4 reserved
    {1'b0, 4'd4, 5'h00, 8'h00, 8'h11},
    {1'b0, 4'd4, 5'h16, 8'h00, 8'h00},
    {1'b0, 4'd4, 5'h14, 8'h00, 8'h05},
    {1'b1, 4'd3, 5'h1F, 8'hAA, 8'h00},  // R3 secondary
    {1'b0, 4'd1, 5'h1F, 8'h00, 8'hAA},
    {1'b1, 4'd5, 5'h00, 8'h44, 8'h00},  // R5
    {1'b1, 4'd5, 5'h02, 8'h55, 8'h00},
    {1'b0, 4'd5, 5'h00, 8'h00, 8'h44},
    {1'b0, 4'd5, 5'h02, 8'h00, 8'h00},
    {1'b0, 4'd5, 5'h07, 8'h00, 8'h00},
    {1'b1, 4'd3, 5'h1F, 8'h01, 8'h00},  // R3 per-channel
    {1'b1, 4'd6, 5'h07, 8'h66, 8'h00},  // R6
    {1'b1, 4'd6, 5'h08, 8'h77, 8'h00},
    {1'b0, 4'd6, 5'h07, 8'h00, 8'h66},
    {1'b0, 4'd6, 5'h08, 8'h00, 8'h00},
    {1'b1, 4'd3, 5'h1F, 8'h02, 8'h00},  // R3 test-pattern
    {1'b1, 4'd6, 5'h08, 8'h88, 8'h00},
    {1'b1, 4'd6, 5'h09, 8'h99, 8'h00},
    {1'b0, 4'd6, 5'h08, 8'h00, 8'h88},
    {1'b0, 4'd6, 5'h09, 8'h00, 8'h00},
    {1'b1, 4'd7, 5'h1F, 8'h5C, 8'h00},  // R7 undefined code
    {1'b1, 4'd7, 5'h00, 8'hEE, 8'h00},
    {1'b0, 4'd7, 5'h00, 8'h00, 8'h00},
    {1'b0, 4'd1, 5'h1F, 8'h00, 8'h5C},
    {1'b1, 4'd3, 5'h1F, 8'h00, 8'h00},
    {1'b0, 4'd3, 5'h00, 8'h00, 8'h11}   // R3/R7 primary untouched
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [DW-1:0] e);
    @(negedge clk); chan_evt = e;
    @(negedge clk); chan_evt = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    check("R2 rd_data", rd_data, 8'h00);
    check("R2 irq", {7'b0, irq}, 8'h00);
    rd(5'h1F, v); check("R2 pointer", v, 8'h00);
    rd(5'h15, v); check("R2 status", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) wr(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][20:16], v);
        check($sformatf("R%0d vec%0d", VEC[i][24:21], i), v, VEC[i][7:0]);
      end
    end

    // R8/R12: event sets status, enabled bit raises irq (enable = 05h)
    pulse(8'h05);
    check("R12 irq set", {7'b0, irq}, 8'h01);
    rd(5'h15, v); check("R8 status latched", v, 8'h05);
    rd(5'h15, v); check("R9 cleared by read", v, 8'h00);
    check("R12 irq cleared", {7'b0, irq}, 8'h00);

    // R9: write ignored in clear-on-read mode
    pulse(8'h02);
    wr(5'h15, 8'hFF);
    rd(5'h15, v); check("R9 write ignored", v, 8'h02);

    // R11: event collides with clearing read
    pulse(8'h05);
    @(negedge clk); rd_en = 1'b1; addr = 5'h15; chan_evt = 8'h04;
    @(negedge clk); rd_en = 1'b0; chan_evt = '0;
    check("R11 read value", rd_data, 8'h05);
    rd(5'h15, v); check("R11 event kept on read", v, 8'h04);

    // R6/R10: switch to clear-on-write
    wr(5'h1F, 8'h01); wr(5'h1E, 8'h01);
    rd(5'h1E, v); check("R6 policy reg", v, 8'h01);
    wr(5'h1F, 8'h00);
    pulse(8'h0F);
    rd(5'h15, v); check("R10 status", v, 8'h0F);
    rd(5'h15, v); check("R10 read keeps", v, 8'h0F);
    wr(5'h15, 8'h03);
    rd(5'h15, v); check("R10 partial clear", v, 8'h0C);
    check("R12 irq enabled bit", {7'b0, irq}, 8'h01);
    wr(5'h15, 8'h04);
    check("R12 irq masked bit only", {7'b0, irq}, 8'h00);
    rd(5'h15, v); check("R10 second clear", v, 8'h08);

    // R11: event collides with clearing write
    @(negedge clk); wr_en = 1'b1; addr = 5'h15; wr_data = 8'h08; chan_evt = 8'h08;
    @(negedge clk); wr_en = 1'b0; chan_evt = '0;
    rd(5'h15, v); check("R11 event kept on write", v, 8'h08);

    // R2: reset returns to primary bank with clean state
    wr(5'h1F, 8'hAA);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'h1F, v); check("R2 pointer after reset", v, 8'h00);
    rd(5'h00, v); check("R2 storage after reset", v, 8'h00);
    rd(5'h15, v); check("R2 status after reset", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule